// File: doc/BRIEF.md
# Two-Dimensional Decoded Single-Bit Lookup Memory

This block is a lookup memory of 2^ADDR_W one-bit cells. It acts as a truth table: the read address forms the inputs of a function, and the single output bit gives that function's value. The cells sit in a grid of rows and columns that is close to square. The upper part of the read address goes to a one-hot decoder that drives exactly one word line. Each column has a bit line that a selected cell pulls low when that cell is in the connected state. The lower part of the address drives a column multiplexer that picks one bit line and inverts it onto the output. Because of this, every cell stores the complement of the value the output shows.

The read path holds no registers, so a change on the read address shows up on the output within the same clock cycle. A clocked load port writes the contents one cell at a time. The caller gives the port the value that should appear at the output, and the block stores its inverse. An active-low asynchronous reset puts every cell in the unconnected state, so the whole table then reads zero. The parameter MUX_STYLE picks how the column multiplexer is built: a direct indexed select or a binary tree of 2:1 stages. The function is the same either way.

Top module: `rom2d_bit_top`

## Requirements
- R1: While reset is held and after it is released, with no load since, every address reads 0 on rd_data.
- R2: A load (load_en high at a rising clk edge) makes rd_data equal to load_bit at address load_addr. The new value is visible from that edge onwards.
- R3: rd_data is a combinational function of rd_addr and the stored contents. A new rd_addr is reflected before the next clock edge. A load to the address being read shows the old value until the edge on which the load is taken.
- R4: A load changes only the addressed cell. Cells in the same row and cells in the same column keep their values.
- R5: While load_en is low, load_addr and load_bit have no effect on any cell.
- R6: The row is rd_addr[ADDR_W-1:ADDR_W/2] and the column is rd_addr[ADDR_W/2-1:0]. Exactly one word line is active for any read address. When load_en is high, exactly one write row is selected. When load_en is low, no write row is selected.
- R7: Any truth table of the ADDR_W address bits can be loaded and read back in full.
- R8: Loading 0 over a cell that holds 1 returns that cell to reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the load port |
| rst_n | input | 1 | Asynchronous active-low reset, clears the table to all zero |
| load_en | input | 1 | Write strobe for one cell |
| load_addr | input | ADDR_W | Address of the cell to write |
| load_bit | input | 1 | Value the cell should show at the output |
| rd_addr | input | ADDR_W | Lookup address (row bits high, column bits low) |
| rd_data | output | 1 | Table value at rd_addr |

## Verification
A read result is due in the same cycle as its address. The bench therefore changes rd_addr on the falling clock edge and samples rd_data one nanosecond later, which is well before the next rising edge. A load is due one rising edge after load_en is raised. The bench drives the load on a falling edge and only reads the cell again after the following rising edge. Where the read and the load hit the same cell in one cycle, it expects the old value before that edge. The expected values go into a queue when each address is driven and are popped when rd_data is sampled.

// File: rtl/rom2d_pkg.sv
`timescale 1ns/1ps
package rom2d_pkg;

   typedef enum logic [0:0] {
      MUX_INDEX = 1'b0,
      MUX_TREE  = 1'b1
   } mux_style_e;

   function automatic int row_bits(input int addr_w);
      return (addr_w + 1) / 2;
   endfunction

   function automatic int col_bits(input int addr_w);
      return addr_w / 2;
   endfunction

endpackage

// File: rtl/rom2d_row_dec.sv
`timescale 1ns/1ps
module rom2d_row_dec #(
   parameter int SEL_W = 4,
   localparam int LINES = 1 << SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [LINES-1:0] line
);

   if (SEL_W < 1) begin : g_bad_width
      $error("rom2d_row_dec: SEL_W must be at least 1");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign line[i] = en && (sel == SEL_W'(i));
   end

endmodule

// File: rtl/rom2d_cell_array.sv
`timescale 1ns/1ps
module rom2d_cell_array #(
   parameter int ROW_W = 4,
   parameter int COL_W = 4,
   localparam int ROWS = 1 << ROW_W,
   localparam int COLS = 1 << COL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROWS-1:0]  wr_line,
   input  logic [COL_W-1:0] wr_col,
   input  logic             wr_bit,
   input  logic [ROWS-1:0]  rd_line,
   output logic [COLS-1:0]  bit_line
);

   // Stored 0 = connected cell (pulls its bit line low when selected).
   logic [COLS-1:0] cell_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q[r] <= '1;
         end else if (wr_line[r]) begin
            cell_q[r][wr_col] <= ~wr_bit;
         end
      end
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      always_comb begin
         bit_line[c] = 1'b1;
         for (int r = 0; r < ROWS; r++) begin
            if (rd_line[r] && !cell_q[r][c]) bit_line[c] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/rom2d_col_mux.sv
`timescale 1ns/1ps
module rom2d_col_mux
   import rom2d_pkg::*;
#(
   parameter int         COL_W     = 4,
   parameter mux_style_e MUX_STYLE = MUX_INDEX,
   localparam int COLS = 1 << COL_W
) (
   input  logic [COLS-1:0]  bit_line,
   input  logic [COL_W-1:0] sel,
   output logic             out_bit
);

   logic picked;

   if (MUX_STYLE == MUX_TREE) begin : g_tree
      logic [COLS-1:0] lvl [COL_W+1];
      assign lvl[0] = bit_line;
      for (genvar l = 0; l < COL_W; l++) begin : g_lvl
         localparam int NODES = COLS >> (l + 1);
         for (genvar i = 0; i < NODES; i++) begin : g_node
            assign lvl[l+1][i] = sel[l] ? lvl[l][2*i+1] : lvl[l][2*i];
         end
         for (genvar j = NODES; j < COLS; j++) begin : g_pad
            assign lvl[l+1][j] = 1'b0;
         end
      end
      assign picked = lvl[COL_W][0];
   end else begin : g_index
      assign picked = bit_line[sel];
   end

   // Bit line is inverted on its way to the output.
   assign out_bit = ~picked;

endmodule

// File: rtl/rom2d_bit_top.sv
`timescale 1ns/1ps
module rom2d_bit_top
   import rom2d_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter mux_style_e MUX_STYLE = MUX_TREE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              load_bit,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_data
);

   localparam int ROW_W = row_bits(ADDR_W);
   localparam int COL_W = col_bits(ADDR_W);
   localparam int ROWS  = 1 << ROW_W;
   localparam int COLS  = 1 << COL_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("rom2d_bit_top: ADDR_W must lie in 2..12");
   end
   if (ROW_W + COL_W != ADDR_W) begin : g_bad_split
      $error("rom2d_bit_top: address split does not cover ADDR_W");
   end

   logic [ROW_W-1:0] rd_row, wr_row;
   logic [COL_W-1:0] rd_col, wr_col;
   logic [ROWS-1:0]  rd_wl, wr_wl;
   logic [COLS-1:0]  bit_line;

   assign rd_row = rd_addr[ADDR_W-1:COL_W];
   assign rd_col = rd_addr[COL_W-1:0];
   assign wr_row = load_addr[ADDR_W-1:COL_W];
   assign wr_col = load_addr[COL_W-1:0];

   rom2d_row_dec #(.SEL_W(ROW_W)) u_rd_dec (
      .en   (1'b1),
      .sel  (rd_row),
      .line (rd_wl)
   );

   rom2d_row_dec #(.SEL_W(ROW_W)) u_wr_dec (
      .en   (load_en),
      .sel  (wr_row),
      .line (wr_wl)
   );

   rom2d_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_line  (wr_wl),
      .wr_col   (wr_col),
      .wr_bit   (load_bit),
      .rd_line  (rd_wl),
      .bit_line (bit_line)
   );

   rom2d_col_mux #(.COL_W(COL_W), .MUX_STYLE(MUX_STYLE)) u_mux (
      .bit_line (bit_line),
      .sel      (rd_col),
      .out_bit  (rd_data)
   );

endmodule

// File: rtl/rom2d_bit_chk.sv
`timescale 1ns/1ps
module rom2d_bit_chk #(
   parameter int ADDR_W = 8,
   parameter int ROWS   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic [ADDR_W-1:0] load_addr,
   input logic              load_bit,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_data,
   input logic [ROWS-1:0]   rd_wl,
   input logic [ROWS-1:0]   wr_wl
);

   p_one_word_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_wl) == 1);

   p_one_write_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> $countones(wr_wl) == 1);

   p_no_write_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |-> wr_wl == '0);

   p_load_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(load_en) && rd_addr == $past(load_addr))
         |-> rd_data == $past(load_bit));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(load_en) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind rom2d_bit_top rom2d_bit_chk #(.ADDR_W(ADDR_W), .ROWS(ROWS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_en   (load_en),
   .load_addr (load_addr),
   .load_bit  (load_bit),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .rd_wl     (rd_wl),
   .wr_wl     (wr_wl)
);

// File: tb/test_rom2d_bit_top.sv
`timescale 1ns/1ps
module test_rom2d_bit_top;

   localparam int AW    = 8;
   localparam int NCELL = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic          load_bit = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_data;

   rom2d_bit_top #(.ADDR_W(AW)) i_rom2d_bit_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_bit  (load_bit),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      logic [AW-1:0] a;
      logic          e;
      string         tag;
   } item_t;

   item_t sb_q[$];
   event  rd_ev;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   bit    model [NCELL];

   // Monitor: sample 1 ns after each driven address, same cycle.
   initial begin
      forever begin
         @(rd_ev);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (rd_data !== it.e) begin
               n_bad++;
               $display("FAIL %s addr=%0h actual=%b expected=%b", it.tag, it.a, rd_data, it.e);
            end
         end
      end
   end

   task automatic push_exp(input int a, input logic e, input string tag);
      rd_addr = AW'(a);
      sb_q.push_back('{AW'(a), e, tag});
      ->rd_ev;
   endtask

   task automatic read_chk(input int a, input string tag);
      @(negedge clk);
      push_exp(a, model[a], tag);
   endtask

   task automatic load(input int a, input logic b);
      @(negedge clk);
      load_en   = 1'b1;
      load_addr = AW'(a);
      load_bit  = b;
      @(negedge clk);
      load_en = 1'b0;
      model[a] = b;
   endtask

   function automatic logic tt_fn(input int a);
      return (^a[AW-1:0]) ^ ((a % 3) == 0);
   endfunction

   initial begin
      for (int i = 0; i < NCELL; i++) model[i] = 1'b0;
      // R1: during reset
      repeat (2) @(negedge clk);
      push_exp(8'h3C, 1'b0, "R1 in reset");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // R1, R3: full sweep after reset, one address per cycle
      for (int a = 0; a < NCELL; a++) read_chk(a, "R1 reset clear");

      // R2 single load, R4 neighbours in row and column
      load(8'h35, 1'b1);
      read_chk(8'h35, "R2 load one");
      read_chk(8'h34, "R4 same row left");
      read_chk(8'h36, "R4 same row right");
      read_chk(8'h25, "R4 same col above");
      read_chk(8'h45, "R4 same col below");

      // R6 row/column split: corner cells
      load(8'h0F, 1'b1);
      load(8'hF0, 1'b1);
      read_chk(8'h0F, "R6 row0 col15");
      read_chk(8'hF0, "R6 row15 col0");
      read_chk(8'hFF, "R6 row15 col15");
      read_chk(8'h00, "R6 row0 col0");
      read_chk(8'h1F, "R6 row1 col15");

      // R5: load_en low ignores port
      @(negedge clk);
      load_en = 1'b0; load_addr = 8'h77; load_bit = 1'b1;
      repeat (3) @(negedge clk);
      load_addr = 8'h35; load_bit = 1'b0;
      repeat (2) @(negedge clk);
      read_chk(8'h77, "R5 idle addr");
      read_chk(8'h35, "R5 idle kept");

      // R3: read and load same cell in one cycle
      @(negedge clk);
      load_en = 1'b1; load_addr = 8'h5A; load_bit = 1'b1;
      push_exp(8'h5A, 1'b0, "R3 old before edge");
      @(negedge clk);
      load_en = 1'b0;
      model[8'h5A] = 1'b1;
      push_exp(8'h5A, 1'b1, "R2 new after edge");

      // R8: overwrite 1 with 0
      load(8'h35, 1'b0);
      read_chk(8'h35, "R8 clear");
      read_chk(8'h5A, "R8 other kept");

      // R7: full truth table
      for (int a = 0; a < NCELL; a++) load(a, tt_fn(a));
      for (int a = NCELL - 1; a >= 0; a--) read_chk(a, "R7 table");

      // R1: reset mid-run clears table
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < NCELL; i++) model[i] = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < NCELL; a += 7) read_chk(a, "R1 re-reset");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R3 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule